// File: doc/BRIEF.md
# Infrared Remote Key Decoder

This block turns the demodulated output of an infrared receiver into key codes. It times every mark and space on the line in units of an external tick. It follows a pulse-distance frame: a long leader, then thirty-two data bits. It checks the frame against a configured customer code and the complement bytes. When the frame is good, it places the data byte in a small key queue for later reading.

A held button sends short repeat frames. The decoder answers each one by queueing the last good key again. It does this only when the previous good frame is recent enough and a programmable holdoff has passed since the last queued key. Any interval whose length falls outside its tolerance window sends the decoder back to idle, where it waits for a fresh leader. The key queue is read with a simple pop strobe.

Top module: `ir_key_decoder`

## Requirements
- R1: After reset the key queue is empty and `key_valid_o` is low.
- R2: The line idles high and a mark is a low level. A frame is a 9 ms mark, a 4.5 ms space and then 32 bits sent least significant bit first. Byte 0 is the customer code, byte 1 its complement, byte 2 the data and byte 3 the data complement. When all checks pass, the data byte is queued and shown on `key_o` with `key_valid_o` high.
- R3: A frame is dropped without queueing when byte 0 differs from `cust_code_i` or byte 1 is not its bitwise inverse.
- R4: A frame is dropped without queueing when byte 3 is not the bitwise inverse of byte 2.
- R5: Each bit is a 560 µs mark followed by a 560 µs space (value 0) or a 1690 µs space (value 1). Every interval is accepted within ±25 % of its nominal length. An interval outside its window aborts the frame with nothing queued, and the next well-formed frame is decoded normally.
- R6: A repeat frame is a 9 ms mark and a 2.25 ms space. When it follows a good frame or a good repeat by no more than 110 ms, and at least `holdoff_i` ticks have passed since the last queued key, it queues the last good data byte again.
- R7: A repeat frame that arrives before `holdoff_i` ticks have passed since the last queued key queues nothing. It still counts as a recent good event for the 110 ms window.
- R8: A repeat frame queues nothing when no good frame has been decoded since reset, or when more than 110 ms have passed since the last good frame or repeat.
- R9: The key queue holds 8 entries and returns them in arrival order. A key that arrives while the queue is full is discarded.
- R10: A pop while the queue is empty has no effect on its contents or order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timing tick, one pulse per 10 µs by default |
| ir_i | input | 1 | Demodulated infrared line, asynchronous |
| cust_code_i | input | 8 | Expected customer code |
| holdoff_i | input | 16 | Minimum ticks between queued keys for repeat frames |
| pop_i | input | 1 | Removes the head key from the queue |
| key_valid_o | output | 1 | Queue holds at least one key |
| key_o | output | 8 | Key at the head of the queue |

## Verification
The holdoff property assumes that `holdoff_i` is held steady while a repeat decision is in flight. The stimulus changes it only while the line is idle, long before the next repeat frame. The repeat and timing rules assume each tick pulse lasts a single clock cycle. The bench drives the tick on every cycle and makes every line interval a whole number of ticks, well inside or well outside each window. `ir_i` is driven one clock at a time, away from the sampling edge.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LDR_MARK,
      ST_LDR_SPACE,
      ST_BIT_MARK,
      ST_BIT_SPACE
   } ir_state_e;

   // Bytes of a received frame; the first bit on the wire lands in bit 0
   typedef struct packed {
      logic [7:0] data_inv;
      logic [7:0] data;
      logic [7:0] cust_inv;
      logic [7:0] cust;
   } ir_frame_t;

   localparam int FRAME_BITS = $bits(ir_frame_t);

endpackage

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
   parameter bit ACTIVE_LOW  = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             line_i,
   output logic             edge_o,
   output logic             mark_start_o,
   output logic [CNT_W-1:0] count_o
);

   localparam logic IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   act;
   logic                   act_q;
   logic [CNT_W-1:0]       cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= {SYNC_STAGES{IDLE_LVL}};
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_active_low
         assign act = ~sync_q[SYNC_STAGES-1];
      end else begin : g_active_high
         assign act = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign edge_o       = act ^ act_q;
   assign mark_start_o = act & ~act_q;
   assign count_o      = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         act_q <= act;
         if (edge_o) begin
            cnt_q <= {{(CNT_W-1){1'b0}}, tick_i};
         end else if (tick_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ir_pulse_fsm.sv
module ir_pulse_fsm
   import ir_dec_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int LDR_MARK_T  = 900,
   parameter int LDR_SPACE_T = 450,
   parameter int RPT_SPACE_T = 225,
   parameter int BIT_MARK_T  = 56,
   parameter int ZERO_T      = 56,
   parameter int ONE_T       = 169,
   parameter int TOL_DIV     = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             edge_i,
   input  logic             mark_start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [7:0]       cust_i,
   output logic             frame_ok_o,
   output logic [7:0]       frame_data_o,
   output logic             rpt_o
);

   localparam int LM_LO = LDR_MARK_T  - LDR_MARK_T  / TOL_DIV;
   localparam int LM_HI = LDR_MARK_T  + LDR_MARK_T  / TOL_DIV;
   localparam int LS_LO = LDR_SPACE_T - LDR_SPACE_T / TOL_DIV;
   localparam int LS_HI = LDR_SPACE_T + LDR_SPACE_T / TOL_DIV;
   localparam int RS_LO = RPT_SPACE_T - RPT_SPACE_T / TOL_DIV;
   localparam int RS_HI = RPT_SPACE_T + RPT_SPACE_T / TOL_DIV;
   localparam int BM_LO = BIT_MARK_T  - BIT_MARK_T  / TOL_DIV;
   localparam int BM_HI = BIT_MARK_T  + BIT_MARK_T  / TOL_DIV;
   localparam int B0_LO = ZERO_T      - ZERO_T      / TOL_DIV;
   localparam int B0_HI = ZERO_T      + ZERO_T      / TOL_DIV;
   localparam int B1_LO = ONE_T       - ONE_T       / TOL_DIV;
   localparam int B1_HI = ONE_T       + ONE_T       / TOL_DIV;
   localparam int BIT_W = $clog2(FRAME_BITS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

   function automatic logic in_win(input logic [CNT_W-1:0] d, input int lo, input int hi);
      return (int'(d) >= lo) && (int'(d) <= hi);
   endfunction

   ir_state_e              state_q, state_d;
   logic [BIT_W-1:0]       bits_q, bits_d;
   logic [FRAME_BITS-1:0]  sr_q, sr_d;
   logic [FRAME_BITS-1:0]  sr_shift;
   logic                   ok_q, ok_d;
   logic                   rpt_q, rpt_d;
   logic [7:0]             data_q, data_d;
   logic                   is_one;
   logic                   is_zero;
   logic                   timeout;
   int                     limit;
   ir_frame_t              fr;

   assign is_one   = in_win(count_i, B1_LO, B1_HI);
   assign is_zero  = in_win(count_i, B0_LO, B0_HI);
   assign sr_shift = {is_one, sr_q[FRAME_BITS-1:1]};
   assign fr       = ir_frame_t'(sr_shift);

   always_comb begin
      case (state_q)
         ST_LDR_MARK:  limit = LM_HI;
         ST_LDR_SPACE: limit = LS_HI;
         ST_BIT_MARK:  limit = BM_HI;
         ST_BIT_SPACE: limit = B1_HI;
         default:      limit = 0;
      endcase
   end

   assign timeout = (state_q != ST_IDLE) && (int'(count_i) > limit);

   always_comb begin
      state_d = state_q;
      bits_d  = bits_q;
      sr_d    = sr_q;
      ok_d    = 1'b0;
      rpt_d   = 1'b0;
      data_d  = data_q;
      if (edge_i) begin
         case (state_q)
            ST_IDLE: begin
               if (mark_start_i) state_d = ST_LDR_MARK;
            end
            ST_LDR_MARK: begin
               state_d = in_win(count_i, LM_LO, LM_HI) ? ST_LDR_SPACE : ST_IDLE;
            end
            ST_LDR_SPACE: begin
               if (in_win(count_i, LS_LO, LS_HI)) begin
                  state_d = ST_BIT_MARK;
                  bits_d  = '0;
               end else begin
                  state_d = ST_IDLE;
                  rpt_d   = in_win(count_i, RS_LO, RS_HI);
               end
            end
            ST_BIT_MARK: begin
               state_d = in_win(count_i, BM_LO, BM_HI) ? ST_BIT_SPACE : ST_IDLE;
            end
            ST_BIT_SPACE: begin
               if (is_one || is_zero) begin
                  sr_d = sr_shift;
                  if (bits_q == LAST_BIT) begin
                     state_d = ST_IDLE;
                     ok_d    = (fr.cust == cust_i) && (fr.cust_inv == ~cust_i)
                               && (fr.data_inv == ~fr.data);
                     if (ok_d) data_d = fr.data;
                  end else begin
                     state_d = ST_BIT_MARK;
                     bits_d  = bits_q + 1'b1;
                  end
               end else begin
                  state_d = ST_IDLE;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end else if (timeout) begin
         state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         bits_q  <= '0;
         sr_q    <= '0;
         ok_q    <= 1'b0;
         rpt_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         bits_q  <= bits_d;
         sr_q    <= sr_d;
         ok_q    <= ok_d;
         rpt_q   <= rpt_d;
         data_q  <= data_d;
      end
   end

   assign frame_ok_o   = ok_q;
   assign frame_data_o = data_q;
   assign rpt_o        = rpt_q;

endmodule

// File: rtl/ir_repeat_gate.sv
module ir_repeat_gate #(
   parameter int HOLD_W = 16,
   parameter int WIN_T  = 11000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              frame_ok_i,
   input  logic [7:0]        frame_data_i,
   input  logic              rpt_i,
   input  logic [HOLD_W-1:0] holdoff_i,
   output logic              push_o,
   output logic              push_rpt_o,
   output logic [7:0]        push_data_o
);

   localparam int WIN_W = $clog2(WIN_T + 2);

   logic [WIN_W-1:0]  since_good_q;
   logic [HOLD_W-1:0] since_push_q;
   logic              armed_q;
   logic [7:0]        last_q;
   logic              rpt_live;
   logic              rpt_fire;

   assign rpt_live = rpt_i && armed_q && (int'(since_good_q) <= WIN_T);
   assign rpt_fire = rpt_live && (since_push_q >= holdoff_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_good_q <= '0;
         since_push_q <= '0;
         armed_q      <= 1'b0;
         last_q       <= '0;
         push_o       <= 1'b0;
         push_rpt_o   <= 1'b0;
         push_data_o  <= '0;
      end else begin
         push_o     <= 1'b0;
         push_rpt_o <= 1'b0;
         if (frame_ok_i) begin
            armed_q      <= 1'b1;
            last_q       <= frame_data_i;
            since_good_q <= '0;
            since_push_q <= '0;
            push_o       <= 1'b1;
            push_data_o  <= frame_data_i;
         end else begin
            if (rpt_live) begin
               since_good_q <= '0;
            end else if (tick_i && (since_good_q != '1)) begin
               since_good_q <= since_good_q + 1'b1;
            end
            if (rpt_fire) begin
               since_push_q <= '0;
               push_o       <= 1'b1;
               push_rpt_o   <= 1'b1;
               push_data_o  <= last_q;
            end else if (tick_i && (since_push_q != '1)) begin
               since_push_q <= since_push_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ir_key_fifo.sv
module ir_key_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       push_i,
   input  logic [W-1:0]               data_i,
   input  logic                       pop_i,
   output logic                       valid_o,
   output logic [W-1:0]               data_o,
   output logic [$clog2(DEPTH+1)-1:0] level_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wp_q;
   logic [AW-1:0] rp_q;
   logic [LW-1:0] lvl_q;
   logic          do_push;
   logic          do_pop;

   assign do_push = push_i && (int'(lvl_q) < DEPTH);
   assign do_pop  = pop_i && (lvl_q != '0);

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wp_q] <= data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   assign valid_o = (lvl_q != '0);
   assign data_o  = mem_q[rp_q];
   assign level_o = lvl_q;

endmodule

// File: rtl/ir_key_decoder.sv
module ir_key_decoder #(
   parameter bit ACTIVE_LOW  = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 12,
   parameter int HOLD_W      = 16,
   parameter int DEPTH       = 8,
   parameter int LDR_MARK_T  = 900,
   parameter int LDR_SPACE_T = 450,
   parameter int RPT_SPACE_T = 225,
   parameter int BIT_MARK_T  = 56,
   parameter int ZERO_T      = 56,
   parameter int ONE_T       = 169,
   parameter int TOL_DIV     = 4,
   parameter int WIN_T       = 11000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              ir_i,
   input  logic [7:0]        cust_code_i,
   input  logic [HOLD_W-1:0] holdoff_i,
   input  logic              pop_i,
   output logic              key_valid_o,
   output logic [7:0]        key_o
);

   localparam int LVL_W = $clog2(DEPTH + 1);

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ir_key_decoder: DEPTH must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ir_key_decoder: SYNC_STAGES must be at least 2");
      end
      if (LDR_MARK_T + LDR_MARK_T / TOL_DIV >= (1 << CNT_W) - 1) begin : g_bad_cnt
         $error("ir_key_decoder: CNT_W too narrow for the leader window");
      end
      if (RPT_SPACE_T + RPT_SPACE_T / TOL_DIV >= LDR_SPACE_T - LDR_SPACE_T / TOL_DIV) begin : g_bad_lsp
         $error("ir_key_decoder: repeat and leader space windows overlap");
      end
      if (ZERO_T + ZERO_T / TOL_DIV >= ONE_T - ONE_T / TOL_DIV) begin : g_bad_bits
         $error("ir_key_decoder: zero and one space windows overlap");
      end
   endgenerate

   logic             edge_ev;
   logic             mark_start;
   logic [CNT_W-1:0] count;
   logic             frame_ok;
   logic [7:0]       frame_data;
   logic             rpt_event;
   logic             push_v;
   logic             push_rpt;
   logic [7:0]       push_data;
   logic [LVL_W-1:0] fifo_level;

   ir_edge_timer #(
      .ACTIVE_LOW (ACTIVE_LOW),
      .SYNC_STAGES(SYNC_STAGES),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .line_i      (ir_i),
      .edge_o      (edge_ev),
      .mark_start_o(mark_start),
      .count_o     (count)
   );

   ir_pulse_fsm #(
      .CNT_W      (CNT_W),
      .LDR_MARK_T (LDR_MARK_T),
      .LDR_SPACE_T(LDR_SPACE_T),
      .RPT_SPACE_T(RPT_SPACE_T),
      .BIT_MARK_T (BIT_MARK_T),
      .ZERO_T     (ZERO_T),
      .ONE_T      (ONE_T),
      .TOL_DIV    (TOL_DIV)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .edge_i      (edge_ev),
      .mark_start_i(mark_start),
      .count_i     (count),
      .cust_i      (cust_code_i),
      .frame_ok_o  (frame_ok),
      .frame_data_o(frame_data),
      .rpt_o       (rpt_event)
   );

   ir_repeat_gate #(
      .HOLD_W(HOLD_W),
      .WIN_T (WIN_T)
   ) u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .frame_ok_i  (frame_ok),
      .frame_data_i(frame_data),
      .rpt_i       (rpt_event),
      .holdoff_i   (holdoff_i),
      .push_o      (push_v),
      .push_rpt_o  (push_rpt),
      .push_data_o (push_data)
   );

   ir_key_fifo #(
      .W    (8),
      .DEPTH(DEPTH)
   ) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push_v),
      .data_i (push_data),
      .pop_i  (pop_i),
      .valid_o(key_valid_o),
      .data_o (key_o),
      .level_o(fifo_level)
   );

endmodule

// File: rtl/ir_key_decoder_checker.sv
module ir_key_decoder_checker #(
   parameter int DEPTH  = 8,
   parameter int HOLD_W = 16,
   parameter int LVL_W  = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic [HOLD_W-1:0] holdoff_i,
   input logic              pop_i,
   input logic              frame_ok,
   input logic              rpt_event,
   input logic              push_v,
   input logic              push_rpt,
   input logic [LVL_W-1:0]  level
);

   logic              seen_frame_q;
   logic [HOLD_W-1:0] ticks_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_frame_q <= 1'b0;
         ticks_q      <= '0;
      end else begin
         if (push_v && !push_rpt) seen_frame_q <= 1'b1;
         if (push_v) ticks_q <= '0;
         else if (tick_i && ticks_q != '1) ticks_q <= ticks_q + 1'b1;
      end
   end

   // R6 / R8: a repeat push needs an earlier frame push
   a_r8_repeat_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_v && push_rpt) |-> seen_frame_q);

   // R7: a repeat push only after the holdoff has run out
   a_r7_holdoff_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_v && push_rpt && seen_frame_q) |-> (ticks_q >= holdoff_i));

   // R9: level never exceeds the depth
   a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(level) <= DEPTH);

   // R9: a push into a full queue is discarded
   a_r9_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(level) == DEPTH && push_v && !pop_i) |=> (int'(level) == DEPTH));

   // R10: popping an empty queue leaves it empty
   a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level == '0 && pop_i && !push_v) |=> (level == '0));

   // R2 / R6: one line interval yields a frame or a repeat, never both
   a_r2_frame_or_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_ok |-> !rpt_event);

endmodule

bind ir_key_decoder ir_key_decoder_checker #(
   .DEPTH (DEPTH),
   .HOLD_W(HOLD_W),
   .LVL_W (LVL_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .tick_i   (tick_i),
   .holdoff_i(holdoff_i),
   .pop_i    (pop_i),
   .frame_ok (frame_ok),
   .rpt_event(rpt_event),
   .push_v   (push_v),
   .push_rpt (push_rpt),
   .level    (fifo_level)
);

// File: tb/ir_key_decoder_bench.sv
`timescale 1ns/1ps
module ir_key_decoder_bench;

   localparam logic [7:0] CUST = 8'hA5;
   // {expect push, customer byte, customer-inverse xor, data, data-inverse xor}
   localparam int NVEC = 6;
   localparam logic [32:0] VEC [NVEC] = '{
      {1'b1, 8'hA5, 8'h00, 8'h3C, 8'h00},   // R2
      {1'b1, 8'hA5, 8'h00, 8'hFF, 8'h00},   // R2
      {1'b0, 8'h5A, 8'h00, 8'h12, 8'h00},   // R3 wrong customer
      {1'b0, 8'hA5, 8'h01, 8'h12, 8'h00},   // R3 bad customer inverse
      {1'b0, 8'hA5, 8'h00, 8'h77, 8'h80},   // R4 bad data inverse
      {1'b1, 8'hA5, 8'h00, 8'h81, 8'h00}    // R2
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        ir = 1'b1;
   logic [15:0] holdoff = 16'd0;
   logic        pop = 1'b0;
   logic        key_valid;
   logic [7:0]  key;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ir_key_decoder u_ir_key_decoder (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .tick_i     (tick),
      .ir_i       (ir),
      .cust_code_i(CUST),
      .holdoff_i  (holdoff),
      .pop_i      (pop),
      .key_valid_o(key_valid),
      .key_o      (key)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hold(input logic lvl, input int n);
      ir = lvl;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] c, input logic [7:0] ci, input logic [7:0] d,
                             input logic [7:0] di, input int pct, input int bad_bit);
      logic [31:0] w;
      w = {di, d, ci, c};
      hold(1'b0, 900 * pct / 100);
      hold(1'b1, 450 * pct / 100);
      for (int i = 0; i < 32; i++) begin
         hold(1'b0, 56 * pct / 100);
         if (i == bad_bit) hold(1'b1, 100);
         else hold(1'b1, (w[i] ? 169 : 56) * pct / 100);
      end
      hold(1'b0, 56);
      hold(1'b1, 200);
   endtask

   task automatic send_repeat();
      hold(1'b0, 900);
      hold(1'b1, 225);
      hold(1'b0, 56);
      hold(1'b1, 200);
   endtask

   task automatic do_pop();
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_key(input logic [7:0] exp, input string req);
      check(key_valid === 1'b1, req, int'(key_valid), 1);
      check(key === exp, req, int'(key), int'(exp));
      do_pop();
   endtask

   task automatic expect_empty(input string req);
      check(key_valid === 1'b0, req, int'(key_valid), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_empty("R1");

      // R8: repeat with no good frame since reset
      send_repeat();
      expect_empty("R8");

      // R2 R3 R4: table walk
      for (int v = 0; v < NVEC; v++) begin
         logic [32:0] e;
         e = VEC[v];
         send_frame(e[31:24], ~e[31:24] ^ e[23:16], e[15:8], ~e[15:8] ^ e[7:0], 100, -1);
         if (e[32]) expect_key(e[15:8], "R2");
         else if (e[31:24] != CUST || e[23:16] != 8'h00) expect_empty("R3");
         else expect_empty("R4");
      end

      // R5: tolerance at both ends
      send_frame(CUST, ~CUST, 8'h5B, ~8'h5B, 80, -1);
      expect_key(8'h5B, "R5");
      send_frame(CUST, ~CUST, 8'hC3, ~8'hC3, 120, -1);
      expect_key(8'hC3, "R5");

      // R5: out-of-window space aborts, next frame recovers
      send_frame(CUST, ~CUST, 8'h66, ~8'h66, 100, 5);
      expect_empty("R5");
      send_frame(CUST, ~CUST, 8'h29, ~8'h29, 100, -1);
      expect_key(8'h29, "R5");

      // R6: repeat re-queues last key
      send_repeat();
      expect_key(8'h29, "R6");

      // R7: repeat inside holdoff ignored, later repeat accepted
      holdoff = 16'd5000;
      send_frame(CUST, ~CUST, 8'h42, ~8'h42, 100, -1);
      expect_key(8'h42, "R7");
      send_repeat();
      expect_empty("R7");
      hold(1'b1, 4000);
      send_repeat();
      expect_key(8'h42, "R7");
      holdoff = 16'd0;

      // R10: pop on empty, then R9 fill beyond depth
      do_pop();
      expect_empty("R10");
      send_frame(CUST, ~CUST, 8'h11, ~8'h11, 100, -1);
      send_frame(CUST, ~CUST, 8'h22, ~8'h22, 100, -1);
      for (int r = 0; r < 7; r++) send_repeat();
      expect_key(8'h11, "R10");
      for (int r = 0; r < 7; r++) expect_key(8'h22, "R9");
      expect_empty("R9");

      // R8: window expired
      hold(1'b1, 11500);
      send_repeat();
      expect_empty("R8");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule